// File: doc/BRIEF.md
# Three-Channel Reloading Down-Counter Timer

The block holds several independent down-counting timer channels that share one run register and sit behind a small synchronous register bus. Each channel has a writable counter, a reload value and a control word. While a channel runs, its counter steps down by one on every tick of its own prescaler. When the counter is at zero and a tick arrives, it takes the reload value instead of wrapping, sets its underflow flag and, if its interrupt enable is set, drives its interrupt line high until software clears the flag.

Software starts or stops a channel by rewriting its bit in the shared run register. While stopped, a channel's counter holds, and its prescaler is cleared, so each start gives a full first tick period. The control word picks one of five divide ratios, enables the interrupt and shows the flag. A write of zero to the flag clears it. A write of one to the flag leaves it alone.

Top module: `tmr_unit`

## Requirements
- R1: After reset, the run register reads 0. Every reload and counter register reads 0xFFFFFFFF. Every control word reads 0x0000, and every interrupt output is low.
- R2: Registers are decoded only at word-aligned byte addresses (address bits [1:0] equal to 0). The run register is at byte 0x00. Channel k occupies bytes 0x04+12k (reload value), 0x08+12k (counter) and 0x0C+12k (control word).
- R3: Bit k of the run register runs channel k. A write to the run register starts and stops each channel according to its own bit. A stopped channel holds its counter value.
- R4: With divide code 000, a running channel's counter decreases by one every 4 clocks. The first decrement takes effect on the 4th rising edge after the edge that set the run bit.
- R5: Control bits [2:0] select the divide ratio: 001 gives /16, 010 gives /64, 011 gives /256 and 100 gives /1024. Codes 101, 110 and 111 divide by 4.
- R6: A tick that finds the counter at 0 loads the reload value into the counter and sets the underflow flag, which is control bit 8.
- R7: Channel k's interrupt output is high exactly when its underflow flag and its interrupt enable (control bit 5) are both set.
- R8: A control write carrying 0 in bit 8 clears the flag. A control write carrying 1 in bit 8 leaves the flag unchanged.
- R9: Byte enables act per byte on the reload and counter registers. On the control word, byte enable 0 covers the divide code and the interrupt enable, and byte enable 1 covers the flag. On the run register, byte enable 0 covers the run bits.
- R10: Read data is registered and appears on the edge that samples the read strobe. Bits that hold no state read as 0.
- R11: The prescaler restarts from zero whenever a channel starts, so partial tick periods from earlier runs never add up.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq | output | NUM_CH | Per-channel level interrupt |

## Verification
The bench builds the block with its default values: three channels, 32-bit counters, a 10-bit prescaler and a 6-bit address. With these values the /1024 ratio completes a tick in about a thousand cycles, and one channel can be checked for undisturbed state while the others run. Counters are loaded with small values so that underflow and reload occur within a few ticks. Partial prescaler runs of non-multiple lengths show whether a start discards the prescaler phase left over from an earlier run.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BUS_W         = 32;
  localparam int BE_W          = BUS_W / 8;
  localparam int CTRL_W        = 16;
  localparam int CTRL_SEL_W    = 3;
  localparam int CTRL_IE_BIT   = 5;
  localparam int CTRL_FLAG_BIT = 8;
  localparam int WORD_CH_BASE  = 1;
  localparam int WORDS_PER_CH  = 3;
  localparam int WORD_RELOAD   = 0;
  localparam int WORD_COUNT    = 1;
  localparam int WORD_CTRL     = 2;

  typedef enum logic [CTRL_SEL_W-1:0] {
    DIV_4    = 3'd0,
    DIV_16   = 3'd1,
    DIV_64   = 3'd2,
    DIV_256  = 3'd3,
    DIV_1024 = 3'd4
  } div_sel_e;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PRE_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         run,
  input  logic [tmr_pkg::CTRL_SEL_W-1:0] sel,
  output logic                         tick
);
  import tmr_pkg::*;

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    case (div_sel_e'(sel))
      DIV_16:   mask = PRE_W'(15);
      DIV_64:   mask = PRE_W'(63);
      DIV_256:  mask = PRE_W'(255);
      DIV_1024: mask = PRE_W'(1023);
      default:  mask = PRE_W'(3);
    endcase
  end

  assign tick = run && ((pre_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + PRE_W'(1);
  end

  // R11: a fresh start always begins from a cleared prescaler
  p_restart_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> (pre_q == '0));
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        run,
  input  logic                        wr_reload,
  input  logic                        wr_count,
  input  logic                        wr_ctrl,
  input  logic [tmr_pkg::BUS_W-1:0]   wdata,
  input  logic [tmr_pkg::BE_W-1:0]    be,
  output logic [CNT_W-1:0]            reload_o,
  output logic [CNT_W-1:0]            count_o,
  output logic [tmr_pkg::CTRL_W-1:0]  ctrl_o,
  output logic                        irq_o
);
  import tmr_pkg::*;

  localparam int NB = CNT_W / 8;

  logic [CNT_W-1:0]      reload_q, count_q;
  logic [CNT_W-1:0]      reload_wr, count_wr;
  logic [CTRL_SEL_W-1:0] sel_q;
  logic                  ie_q, flag_q;
  logic                  tick, uflow;

  tmr_prescaler #(.PRE_W(PRE_W)) i_pre (
    .clk (clk),
    .rst (rst),
    .run (run),
    .sel (sel_q),
    .tick(tick)
  );

  for (genvar b = 0; b < NB; b++) begin : g_merge
    assign reload_wr[8*b +: 8] = be[b] ? wdata[8*b +: 8] : reload_q[8*b +: 8];
    assign count_wr[8*b +: 8]  = be[b] ? wdata[8*b +: 8] : count_q[8*b +: 8];
  end

  assign uflow = tick && (count_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      reload_q <= '1;
      count_q  <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload) reload_q <= reload_wr;
      if (wr_count)  count_q  <= count_wr;
      else if (tick) count_q  <= uflow ? reload_q : count_q - CNT_W'(1);
      if (wr_ctrl && be[0]) begin
        sel_q <= wdata[CTRL_SEL_W-1:0];
        ie_q  <= wdata[CTRL_IE_BIT];
      end
      if (uflow)                 flag_q <= 1'b1;
      else if (wr_ctrl && be[1]) flag_q <= flag_q & wdata[CTRL_FLAG_BIT];
    end
  end

  always_comb begin
    ctrl_o                  = '0;
    ctrl_o[CTRL_SEL_W-1:0]  = sel_q;
    ctrl_o[CTRL_IE_BIT]     = ie_q;
    ctrl_o[CTRL_FLAG_BIT]   = flag_q;
  end

  assign reload_o = reload_q;
  assign count_o  = count_q;
  assign irq_o    = flag_q & ie_q;

  // R3: a stopped channel with no counter write keeps its value
  p_hold_stopped_r3: assert property (@(posedge clk) disable iff (rst)
    (!run && !wr_count) |=> $stable(count_q));
  // R4: a tick on a nonzero counter steps it down by exactly one
  p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_count && count_q != '0) |=> (count_q == $past(count_q) - CNT_W'(1)));
  // R6: a tick at zero reloads the counter and raises the flag
  p_reload_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && !wr_count && count_q == '0) |=> (count_q == $past(reload_q) && flag_q));
  // R6: the flag only ever rises after an underflow
  p_flag_source_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q) |-> $past(tick && count_q == '0));
endmodule

// File: rtl/tmr_unit.sv
module tmr_unit #(
  parameter int NUM_CH = 3,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 10,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  import tmr_pkg::*;

  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;
  logic              wr_start;
  logic [NUM_CH-1:0] run_q;
  logic [NUM_CH-1:0] wr_rel, wr_cnt, wr_ctl;
  logic [CNT_W-1:0]  rel_v [NUM_CH];
  logic [CNT_W-1:0]  cnt_v [NUM_CH];
  logic [CTRL_W-1:0] ctl_v [NUM_CH];
  logic [31:0]       rd_next;

  assign word     = bus_addr[ADDR_W-1:2];
  assign aligned  = (bus_addr[1:0] == 2'b00);
  assign wr_start = bus_wr && aligned && (word == '0);

  always_ff @(posedge clk) begin
    if (rst)                     run_q <= '0;
    else if (wr_start && bus_be[0]) run_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    localparam int BASE = WORD_CH_BASE + WORDS_PER_CH * k;
    assign wr_rel[k] = bus_wr && aligned && (word == WORD_W'(BASE + WORD_RELOAD));
    assign wr_cnt[k] = bus_wr && aligned && (word == WORD_W'(BASE + WORD_COUNT));
    assign wr_ctl[k] = bus_wr && aligned && (word == WORD_W'(BASE + WORD_CTRL));

    tmr_channel #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_ch (
      .clk      (clk),
      .rst      (rst),
      .run      (run_q[k]),
      .wr_reload(wr_rel[k]),
      .wr_count (wr_cnt[k]),
      .wr_ctrl  (wr_ctl[k]),
      .wdata    (bus_wdata),
      .be       (bus_be),
      .reload_o (rel_v[k]),
      .count_o  (cnt_v[k]),
      .ctrl_o   (ctl_v[k]),
      .irq_o    (irq[k])
    );
  end

  always_comb begin
    rd_next = '0;
    if (aligned) begin
      if (word == '0) rd_next[NUM_CH-1:0] = run_q;
      for (int k = 0; k < NUM_CH; k++) begin
        if (word == WORD_W'(WORD_CH_BASE + WORDS_PER_CH * k + WORD_RELOAD))
          rd_next[CNT_W-1:0] = rel_v[k];
        if (word == WORD_W'(WORD_CH_BASE + WORDS_PER_CH * k + WORD_COUNT))
          rd_next[CNT_W-1:0] = cnt_v[k];
        if (word == WORD_W'(WORD_CH_BASE + WORDS_PER_CH * k + WORD_CTRL))
          rd_next[CTRL_W-1:0] = ctl_v[k];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_next;
  end

  // R3: a run-register write with byte 0 enabled sets every run bit from its own data bit
  p_start_write_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_start && bus_be[0]) |=> (run_q == $past(bus_wdata[NUM_CH-1:0])));
  // R10: without a read strobe the read data holds
  p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/test_tmr_unit.sv
module test_tmr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_unit i_tmr_unit (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_be(bus_be), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [5:0] a_rel(input int k); return 6'(4 + 12*k);  endfunction
  function automatic logic [5:0] a_cnt(input int k); return 6'(8 + 12*k);  endfunction
  function automatic logic [5:0] a_ctl(input int k); return 6'(12 + 12*k); endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
    bus_addr = a; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d);    check("R1 run reg", d, 32'h0);
    rd(a_rel(0), d); check("R1 reload ch0", d, 32'hFFFF_FFFF);
    rd(a_cnt(1), d); check("R1 counter ch1", d, 32'hFFFF_FFFF);
    rd(a_ctl(2), d); check("R1 ctrl ch2", d, 32'h0);
    check("R1 irq", {29'b0, irq}, 32'h0);
  endtask

  task automatic t_div4_and_hold;
    logic [31:0] d;
    wr(a_cnt(0), 32'd10);
    wr(6'h00, 32'h1);
    idle(11);
    wr(6'h00, 32'h0);               // stop edge is the 12th: three ticks
    rd(a_cnt(0), d); check("R4 three ticks at /4", d, 32'd7);
    idle(20);
    rd(a_cnt(0), d); check("R3 stopped counter holds", d, 32'd7);
  endtask

  task automatic t_restart;
    logic [31:0] d;
    wr(6'h00, 32'h1); idle(1); wr(6'h00, 32'h0);   // two prescaler clocks
    wr(6'h00, 32'h1); idle(2); wr(6'h00, 32'h0);   // three prescaler clocks
    rd(a_cnt(0), d); check("R11 partial periods do not add", d, 32'd7);
  endtask

  task automatic t_independent;
    logic [31:0] d;
    wr(a_cnt(1), 32'd50);
    wr(a_cnt(2), 32'd60);
    wr(6'h00, 32'h5);               // channels 0 and 2 only
    idle(7);
    wr(6'h00, 32'h0);               // eighth edge: two ticks
    rd(a_cnt(0), d); check("R3 ch0 ran", d, 32'd5);
    rd(a_cnt(1), d); check("R3 ch1 untouched", d, 32'd50);
    rd(a_cnt(2), d); check("R3 ch2 ran", d, 32'd58);
  endtask

  task automatic t_prescale;
    logic [31:0] d;
    wr(a_ctl(1), 32'h1);            // /16
    wr(a_cnt(1), 32'd100);
    wr(6'h00, 32'h2); idle(31); wr(6'h00, 32'h0);
    rd(a_cnt(1), d); check("R5 /16", d, 32'd98);
    wr(a_ctl(1), 32'h2);            // /64
    wr(6'h00, 32'h2); idle(63); wr(6'h00, 32'h0);
    rd(a_cnt(1), d); check("R5 /64", d, 32'd97);
    wr(a_ctl(1), 32'h3);            // /256
    wr(6'h00, 32'h2); idle(254); wr(6'h00, 32'h0);
    rd(a_cnt(1), d); check("R5 /256 just short", d, 32'd97);
    wr(a_ctl(1), 32'h4);            // /1024
    wr(6'h00, 32'h2); idle(1023); wr(6'h00, 32'h0);
    rd(a_cnt(1), d); check("R5 /1024", d, 32'd96);
    wr(a_ctl(1), 32'h5);            // unused code -> /4
    wr(6'h00, 32'h2); idle(7); wr(6'h00, 32'h0);
    rd(a_cnt(1), d); check("R5 code 101 as /4", d, 32'd94);
  endtask

  task automatic t_underflow;
    logic [31:0] d;
    wr(a_rel(2), 32'd5);
    wr(a_cnt(2), 32'd1);
    wr(a_ctl(2), 32'h20);
    wr(6'h00, 32'h4); idle(7); wr(6'h00, 32'h0);
    rd(a_cnt(2), d); check("R6 reload after underflow", d, 32'd5);
    rd(a_ctl(2), d); check("R6 flag set", d, 32'h120);
    check("R7 irq with enable", {29'b0, irq}, 32'h4);
    wr(a_ctl(2), 32'h120);
    rd(a_ctl(2), d); check("R8 write 1 keeps flag", d, 32'h120);
    wr(a_ctl(2), 32'h20);
    rd(a_ctl(2), d); check("R8 write 0 clears flag", d, 32'h20);
    check("R8 irq dropped", {29'b0, irq}, 32'h0);
  endtask

  task automatic t_enable_gating;
    logic [31:0] d;
    wr(a_ctl(2), 32'h0);
    wr(a_cnt(2), 32'd0);
    wr(6'h00, 32'h4); idle(3); wr(6'h00, 32'h0);
    rd(a_ctl(2), d); check("R7 flag without enable", d, 32'h100);
    check("R7 irq low when disabled", {29'b0, irq}, 32'h0);
    wr(a_ctl(2), 32'h20, 4'b0001);   // byte 1 off: flag untouched
    check("R9 low byte sets enable, irq up", {29'b0, irq}, 32'h4);
    rd(a_ctl(2), d); check("R9 flag kept", d, 32'h120);
    wr(a_ctl(2), 32'h0, 4'b0010);    // only flag byte
    rd(a_ctl(2), d); check("R9 flag byte clears only flag", d, 32'h20);
  endtask

  task automatic t_bytes_and_map;
    logic [31:0] d;
    wr(a_rel(0), 32'hFFFF_FFFF);
    wr(a_rel(0), 32'hA5A5_A5A5, 4'b0101);
    rd(a_rel(0), d); check("R9 reload byte merge", d, 32'hFFA5_FFA5);
    wr(a_ctl(0), 32'hFFFF_FFFF);
    rd(a_ctl(0), d); check("R10 ctrl unused bits zero", d, 32'h27);
    wr(6'h00, 32'hFF, 4'b0000);
    rd(6'h00, d); check("R9 run write without enable", d, 32'h0);
    wr(6'h00, 32'hFFF8);
    rd(6'h00, d); check("R10 run unused bits zero", d, 32'h0);
    wr(6'h11, 32'h1234_5678);        // misaligned: ignored
    rd(a_rel(1), d); check("R2 misaligned write ignored", d, 32'hFFFF_FFFF);
    wr(a_rel(1), 32'h1234_5678);
    rd(6'h10, d); check("R2 ch1 reload at 0x10", d, 32'h1234_5678);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_div4_and_hold();
    t_restart();
    t_independent();
    t_prescale();
    t_underflow();
    t_enable_gating();
    t_bytes_and_map();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule